// File: doc/BRIEF.md
# Cascaded Fall-Through FIFO Chain

This block builds one deep queue out of `N` identical first-word-fall-through stages. Each stage feeds its data output straight into the data input of the next stage. Two flags form the whole handshake between neighbours. A stage's active-low valid flag drops when it presents a word. A stage's active-low room flag drops when it has a free slot. When the upstream valid flag and the downstream room flag are both low, one word moves on the next clock edge. No other glue sits between the stages.

A single clock runs writes, reads and transfers. A word written into an empty chain falls through to the last stage's output without any read request. A slot freed at the tail of a full chain travels back to the head. Both journeys take a fixed number of cycles per stage. Once the tail holds data, words stream out one per cycle. The full capacity is `N*DEPTH` words. A synchronous, active-high reset empties every stage and puts every stage in fall-through behaviour.

Top module: `fwft_chain`

## Requirements
- R1: While `rst` is sampled high at a clock edge, every stage is emptied. After that edge `avail_n` is 1 and `space_n` is 0, and no earlier word appears at the output afterwards.
- R2: Words leave at `dout` in the order they were accepted and with their values unchanged. The default width is 9 bits. A write is accepted at an edge where `wr_en`=1 and `space_n`=0. A read is accepted at an edge where `rd_en`=1 and `avail_n`=0.
- R3: Starting from empty, with no reads, exactly `N*DEPTH` writes are accepted. After that `space_n` stays 1.
- R4: In an empty chain, the first write is accepted at edge 0. `avail_n` first reads 0 after edge `4*(N-1)+3`, and no read is needed for this.
- R5: In a full, settled chain, one read is accepted at edge 0. `space_n` first reads 0 after edge `3*(N-1)+2`.
- R6: From a full, settled chain, `DEPTH` reads on consecutive edges each find `avail_n`=0. The ripple delay applies only to a word entering an empty chain.
- R7: A write with `space_n`=1 is ignored. Its data never appears at `dout`.
- R8: A read with `avail_n`=1 is ignored. A word written afterwards is still the first word presented.
- R9: While `avail_n`=0 and `rd_en`=0, `dout` and `avail_n` hold their values on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for writes, reads and inter-stage transfers |
| rst | input | 1 | Synchronous active-high reset |
| din | input | DW | Write data into the head stage |
| wr_en | input | 1 | Write request, active high |
| space_n | output | 1 | Head stage has a free slot when 0 |
| dout | output | DW | Word presented by the tail stage |
| rd_en | input | 1 | Read request, active high |
| avail_n | output | 1 | Tail stage presents a valid word when 0 |

## Verification
The hardest case to reach is the freed slot travelling back through a chain in which every stage is full. Every stage must first hold exactly `DEPTH` words with all transfers settled, and only then is a single read issued. The bench gets there by holding the write request high long after the head flag goes high. It then idles until the chain is quiet, pulses one read, and counts cycles until the head flag drops. Three chains of lengths one, two and three share this stimulus, so the per-stage latency steps can be compared against the formulas in a single run.

// File: rtl/fwft_chain_pkg.sv
`timescale 1ns/1ps
package fwft_chain_pkg;
    // Default data path width
    localparam int DATA_W   = 9;
    // Edges between an accepted write and the word becoming loadable
    localparam int SHOW_LAT = 2;
    // Edges between an accepted read and the slot counting as free
    localparam int FREE_LAT = 2;
endpackage

// File: rtl/fwft_delay.sv
`timescale 1ns/1ps
module fwft_delay #(
    parameter int LEN = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [LEN-1:0] sh;

    generate
        if (LEN == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sh <= '0;
                else     sh <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) sh <= '0;
                else     sh <= {sh[LEN-2:0], d};
            end
        end
    endgenerate

    assign q = sh[LEN-1];
endmodule

// File: rtl/fwft_stage.sv
`timescale 1ns/1ps
module fwft_stage
    import fwft_chain_pkg::*;
#(
    parameter int DW    = DATA_W,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_req,
    output logic          room_n,
    input  logic          rd_req,
    output logic [DW-1:0] rd_data,
    output logic          valid_n
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr, lptr;
    logic [CW-1:0] used, avail;
    logic [DW-1:0] head_q;
    logic          head_v;

    logic wr_fire, rd_fire, load, show_inc, free_dec;

    // Slots count as used from the write until the freeing pipe drains
    assign room_n  = (used == FULL);
    assign wr_fire = wr_req & ~room_n;
    assign rd_fire = rd_req & head_v;
    assign load    = (avail != '0) & (~head_v | rd_fire);

    fwft_delay #(.LEN(SHOW_LAT)) show_pipe_i (
        .clk(clk), .rst(rst), .d(wr_fire), .q(show_inc)
    );

    fwft_delay #(.LEN(FREE_LAT)) free_pipe_i (
        .clk(clk), .rst(rst), .d(rd_fire), .q(free_dec)
    );

    always_ff @(posedge clk) begin
        if (wr_fire) mem[wptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr   <= '0;
            lptr   <= '0;
            used   <= '0;
            avail  <= '0;
            head_v <= 1'b0;
            head_q <= '0;
        end else begin
            if (wr_fire) wptr <= (wptr == LAST) ? '0 : wptr + AW'(1);
            used  <= used + CW'(wr_fire) - CW'(free_dec);
            avail <= avail + CW'(show_inc) - CW'(load);
            if (load) begin
                head_q <= mem[lptr];
                lptr   <= (lptr == LAST) ? '0 : lptr + AW'(1);
                head_v <= 1'b1;
            end else if (rd_fire) begin
                head_v <= 1'b0;
            end
        end
    end

    assign rd_data = head_q;
    assign valid_n = ~head_v;
endmodule

// File: rtl/fwft_chain.sv
`timescale 1ns/1ps
module fwft_chain
    import fwft_chain_pkg::*;
#(
    parameter int DW    = DATA_W,
    parameter int N     = 3,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] din,
    input  logic          wr_en,
    output logic          space_n,
    output logic [DW-1:0] dout,
    input  logic          rd_en,
    output logic          avail_n
);
    logic [DW-1:0] lane [N+1];
    logic [N-1:0]  room_v, valid_v, wreq, rreq;

    assign lane[0]   = din;
    assign wreq[0]   = wr_en;
    assign rreq[N-1] = rd_en;

    generate
        for (genvar k = 0; k < N; k++) begin : g_stage
            fwft_stage #(.DW(DW), .DEPTH(DEPTH)) stage_i (
                .clk     (clk),
                .rst     (rst),
                .wr_data (lane[k]),
                .wr_req  (wreq[k]),
                .room_n  (room_v[k]),
                .rd_req  (rreq[k]),
                .rd_data (lane[k+1]),
                .valid_n (valid_v[k])
            );
            if (k > 0) begin : g_link
                assign wreq[k]   = ~valid_v[k-1] & ~room_v[k];
                assign rreq[k-1] = wreq[k];
            end
        end
    endgenerate

    assign space_n = room_v[0];
    assign avail_n = valid_v[N-1];
    assign dout    = lane[N];
endmodule

// File: rtl/fwft_chain_chk.sv
`timescale 1ns/1ps
module fwft_chain_chk #(
    parameter int DW    = 9,
    parameter int N     = 3,
    parameter int DEPTH = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic          space_n,
    input logic          rd_en,
    input logic          avail_n,
    input logic [DW-1:0] dout
);
    localparam int TOTAL = N * DEPTH;
    localparam int OW    = $clog2(TOTAL + 1) + 1;

    logic [OW-1:0] occ;
    logic acc_w, acc_r;

    assign acc_w = wr_en & ~space_n;
    assign acc_r = rd_en & ~avail_n;

    always_ff @(posedge clk) begin
        if (rst) occ <= '0;
        else     occ <= occ + OW'(acc_w) - OW'(acc_r);
    end

    p_reset_flags_r1: assert property (@(posedge clk)
        rst |=> (avail_n && !space_n));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        occ <= OW'(TOTAL));

    p_full_blocks_r7: assert property (@(posedge clk) disable iff (rst)
        (occ == OW'(TOTAL)) |-> space_n);

    p_empty_no_word_r8: assert property (@(posedge clk) disable iff (rst)
        (occ == '0) |-> avail_n);

    p_head_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!avail_n && !rd_en) |=> (!avail_n && $stable(dout)));
endmodule

bind fwft_chain fwft_chain_chk #(.DW(DW), .N(N), .DEPTH(DEPTH)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .space_n (space_n),
    .rd_en   (rd_en),
    .avail_n (avail_n),
    .dout    (dout)
);

// File: tb/fwft_chain_tb_top.sv
`timescale 1ns/1ps
module fwft_chain_tb_top;
    localparam int DW = 9;
    localparam int D  = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [DW-1:0] din = '0;
    logic wr_en = 1'b0;
    logic rd_en = 1'b0;

    logic          sp_a, av_a, sp_b, av_b, sp_c, av_c;
    logic [DW-1:0] do_a, do_b, do_c;

    always #2.5 clk = ~clk;

    // a: N=3 (model-checked), b: N=1, c: N=2
    fwft_chain #(.DW(DW), .N(3), .DEPTH(D)) dut_i (
        .clk(clk), .rst(rst), .din(din), .wr_en(wr_en), .space_n(sp_a),
        .dout(do_a), .rd_en(rd_en), .avail_n(av_a));
    fwft_chain #(.DW(DW), .N(1), .DEPTH(D)) dut_n1_i (
        .clk(clk), .rst(rst), .din(din), .wr_en(wr_en), .space_n(sp_b),
        .dout(do_b), .rd_en(rd_en), .avail_n(av_b));
    fwft_chain #(.DW(DW), .N(2), .DEPTH(D)) dut_n2_i (
        .clk(clk), .rst(rst), .din(din), .wr_en(wr_en), .space_n(sp_c),
        .dout(do_c), .rd_en(rd_en), .avail_n(av_c));

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    logic [DW-1:0] seq = '0;
    logic [DW-1:0] q[$];
    int acc_a, acc_b, acc_c;

    // Phase table: [15:8] cycles, [7:4] write mode, [3:0] read mode
    // mode 0 off, 1 every cycle, 2 every second, 3 every third
    localparam logic [15:0] PHASES [8] = '{
        16'h1410, 16'h1001, 16'h3C11, 16'h3C13, 16'h3C31,
        16'h2821, 16'h2812, 16'h4001
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit mode_on(input logic [3:0] m, input int j);
        case (m)
            4'd1:    return 1'b1;
            4'd2:    return (j % 2) == 0;
            4'd3:    return (j % 3) == 0;
            default: return 1'b0;
        endcase
    endfunction

    // Called at a falling edge: drive, account against current flags, advance
    task automatic tick(input bit w, input bit r);
        wr_en = w;
        rd_en = r;
        din   = seq;
        if (w && !sp_a) begin q.push_back(seq); acc_a++; end
        if (w && !sp_b) acc_b++;
        if (w && !sp_c) acc_c++;
        if (r && !av_a) begin
            if (q.size() == 0) check(1'b0, "R2 read with empty model", 1, 0);
            else begin
                check(do_a == q[0], "R2 order", int'(do_a), int'(q[0]));
                void'(q.pop_front());
            end
        end
        seq = seq + 1'b1;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick(1'b0, 1'b0);
        tick(1'b0, 1'b0);
        rst = 1'b0;
        q.delete();
        acc_a = 0; acc_b = 0; acc_c = 0;
    endtask

    task automatic drain();
        int idle = 0;
        while (idle < 40) begin
            if (av_a) idle++; else idle = 0;
            tick(1'b0, 1'b1);
        end
        check(q.size() == 0, "R7 no lost or extra words", q.size(), 0);
        check(av_a == 1'b1, "R7 chain empty after drain", int'(av_a), 1);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 100000);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        int la, lb, lc;
        @(negedge clk);
        do_reset();

        // R1: flags after reset
        check(av_a && !sp_a, "R1 reset flags N=3", {av_a, sp_a}, 2);
        check(av_b && !sp_b, "R1 reset flags N=1", {av_b, sp_b}, 2);
        check(av_c && !sp_c, "R1 reset flags N=2", {av_c, sp_c}, 2);

        // R4: ripple latency of a first word
        tick(1'b1, 1'b0);
        la = -1; lb = -1; lc = -1;
        for (int k = 1; k <= 40; k++) begin
            tick(1'b0, 1'b0);
            if (la < 0 && !av_a) la = k;
            if (lb < 0 && !av_b) lb = k;
            if (lc < 0 && !av_c) lc = k;
        end
        check(la == 11, "R4 fill latency N=3", la, 11);
        check(lb == 3,  "R4 fill latency N=1", lb, 3);
        check(lc == 7,  "R4 fill latency N=2", lc, 7);
        check(do_a == q[0], "R2 first word value", int'(do_a), int'(q[0]));

        // R3: capacity, with R7 ignored writes once full
        do_reset();
        for (int k = 0; k < 200; k++) tick(1'b1, 1'b0);
        for (int k = 0; k < 30; k++) tick(1'b0, 1'b0);
        check(acc_a == 3 * D, "R3 capacity N=3", acc_a, 3 * D);
        check(acc_b == D,     "R3 capacity N=1", acc_b, D);
        check(acc_c == 2 * D, "R3 capacity N=2", acc_c, 2 * D);
        check(sp_a == 1'b1, "R3 head flag high when full", int'(sp_a), 1);

        // R5: bubble latency of a freed slot
        tick(1'b0, 1'b1);
        la = -1; lb = -1; lc = -1;
        for (int k = 1; k <= 40; k++) begin
            tick(1'b0, 1'b0);
            if (la < 0 && !sp_a) la = k;
            if (lb < 0 && !sp_b) lb = k;
            if (lc < 0 && !sp_c) lc = k;
        end
        check(la == 8, "R5 free latency N=3", la, 8);
        check(lb == 2, "R5 free latency N=1", lb, 2);
        check(lc == 5, "R5 free latency N=2", lc, 5);

        // Refill to full, settle, then R6 streaming
        for (int k = 0; k < 10; k++) tick(1'b1, 1'b0);
        for (int k = 0; k < 30; k++) tick(1'b0, 1'b0);
        for (int j = 0; j < D; j++) begin
            check(av_a == 1'b0, "R6 word ready on consecutive read", int'(av_a), 0);
            tick(1'b0, 1'b1);
        end
        drain();

        // R8: reads on an empty chain are ignored
        for (int k = 0; k < 6; k++) tick(1'b0, 1'b1);
        check(av_a == 1'b1, "R8 empty stays empty", int'(av_a), 1);
        tick(1'b1, 1'b0);
        for (int k = 0; k < 20; k++) tick(1'b0, 1'b0);
        check(av_a == 1'b0 && do_a == q[0], "R8 next word presented first",
              int'(do_a), int'(q[0]));

        // R9: head word held without a read
        begin
            logic [DW-1:0] held;
            held = do_a;
            for (int k = 0; k < 5; k++) tick(1'b0, 1'b0);
            check(av_a == 1'b0 && do_a == held, "R9 head held", int'(do_a), int'(held));
        end
        drain();

        // Table walk with model-checked order (R2, R7)
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < int'(PHASES[i][15:8]); j++)
                tick(mode_on(PHASES[i][7:4], j), mode_on(PHASES[i][3:0], j));
        end
        drain();

        // R1: reset in the middle of traffic empties the chain
        for (int k = 0; k < 30; k++) tick(1'b1, 1'b0);
        rst = 1'b1;
        tick(1'b0, 1'b0);
        check(av_a && !sp_a, "R1 mid-run reset flags", {av_a, sp_a}, 2);
        rst = 1'b0;
        q.delete();
        for (int k = 0; k < 40; k++) tick(1'b0, 1'b0);
        check(av_a == 1'b1, "R1 no old word after reset", int'(av_a), 1);

        finish_run();
    end
endmodule